// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache

This block sits between a processor's instruction fetch port and a slower 32-bit memory bus. It holds 1 KB of read-only code in 64 lines of 16 bytes. Each line has one tag and one valid bit. A fetch that hits is answered combinationally in the cycle it is presented. A fetch that misses loads the whole line into a line-fill buffer with four word reads on the bus. The line is then written into storage and the requested word goes back to the processor.

A two-bit control register turns caching on and can clear every valid bit in a single write. A separate request drops one line, chosen by its index. Reset clears the register. After reset the cache is therefore disabled, and each fetch becomes one plain bus read that leaves the stored lines untouched. An invalidation that lands while a line is being filled is honoured: the line being filled ends up invalid. The fetch that started the fill still receives its word from the fill buffer.

The processor holds `fetch_req` and `fetch_addr` steady until `fetch_ready` is seen at a clock edge. The bus side holds `bus_req` and `bus_addr` steady until a one-cycle `bus_ack`, which comes with the read data.

Top module: `ifetch_cache`

## Requirements
- R1: After reset the control register reads 0 (caching disabled) and every line is invalid, so the first cached fetch to any address after enabling is a miss.
- R2: The fetch address splits into word select bits [3:2], line index bits [9:4] and tag bits [31:10]. A hit needs the indexed line to be valid and its stored tag to equal the fetch tag. Two addresses with the same index but different tags evict each other.
- R3: A hit raises `fetch_ready` with the correct word in the same cycle as `fetch_req`, and makes no bus request.
- R4: A miss with caching enabled issues exactly four bus reads, in the order line base +0, +4, +8, +12. The requested word is returned in the cycle after the fourth `bus_ack`. The line becomes valid only when all four words have arrived.
- R5: With caching disabled, a fetch issues exactly one bus read at the word-aligned fetch address. It returns that word in the cycle after `bus_ack`, and it changes no tag or valid bit: a line cached before the cache was disabled still hits after caching is enabled again.
- R6: Control bit 0 enables caching. Writing 1 to control bit 1 clears every valid bit. Bit 1 is never stored and always reads back as 0.
- R7: A single-line invalidate clears the valid bit of the line at `line_inv_idx` only. Other lines keep hitting.
- R8: A single-line invalidate of the line being filled, or an invalidate-all, arriving during a fill leaves that line invalid once the fill ends. The pending fetch still gets the correct word.
- R9: `bus_addr` is always word aligned. While `bus_req` is high without `bus_ack`, both `bus_req` and `bus_addr` hold their values in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch request, held until `fetch_ready` |
| fetch_addr | input | 30 | Fetch byte address bits [31:2] |
| fetch_ready | output | 1 | Fetch answered this cycle |
| fetch_data | output | 32 | Instruction word, valid with `fetch_ready` |
| bus_req | output | 1 | Bus read request |
| bus_addr | output | 32 | Word-aligned bus read address |
| bus_ack | input | 1 | One-cycle read completion |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 2 | Bit 0 enable, bit 1 invalidate all |
| ctrl_rdata | output | 2 | Control readback: bit 0 enable, bit 1 always 0 |
| line_inv | input | 1 | Single-line invalidate request |
| line_inv_idx | input | 6 | Index of the line to invalidate |

## Verification
The bench drives fetches against a behavioural model that keeps its own valid and tag tables and predicts, for each fetch, whether it hits, how many bus reads it makes, at which addresses and in what order, and which word comes back. It aims at the index alias at addresses 0x100 and 0x500: a design that compared only part of the tag would return stale code from the wrong line. It aims at an invalidate that arrives in mid-fill: a design that set the valid bit unconditionally at the end of the fill would hit on the next access, where the model expects four new bus reads. It aims at fetches made while caching is off: a design that installed such lines, or wiped the stored lines, would differ from the model once caching is back on. It also checks that the invalidate-all bit reads back as zero, that a single-line invalidate spares its neighbours, and that the highest tag value compares correctly.

// File: rtl/icache_pkg.sv
package icache_pkg;

    // control register bit positions
    localparam int CTL_EN_BIT     = 0;
    localparam int CTL_INVALL_BIT = 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_SINGLE = 2'd2,
        ST_RESP   = 2'd3
    } ic_state_e;

endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
    parameter int LINES = 64,
    parameter int TAG_W = 22,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_set,
    input  logic             inv_all,
    input  logic             inv_line,
    input  logic [IDX_W-1:0] inv_idx
);

    logic [LINES-1:0] valid_d, valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // install first, then apply invalidations so a same-cycle kill wins
    always_comb begin
        valid_d = valid_q;
        if (wr_en) begin
            valid_d[wr_idx] = wr_set;
        end
        if (inv_line) begin
            valid_d[inv_idx] = 1'b0;
        end
        if (inv_all) begin
            valid_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    // tags need no reset: they are ignored while the valid bit is clear
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];

endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
    parameter int LINES  = 64,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [WORDS-1:0][DATA_W-1:0] wr_line,
    input  logic [IDX_W-1:0]             rd_idx,
    input  logic [WSEL_W-1:0]            rd_word,
    output logic [DATA_W-1:0]            rd_data
);

    logic [WORDS-1:0][DATA_W-1:0] line_q [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_idx] <= wr_line;
        end
    end

    assign rd_data = line_q[rd_idx][rd_word];

endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl
    import icache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINES  = 64,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int OFF_W  = WSEL_W + 2,
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fetch_req,
    input  logic [ADDR_W-1:2]            fetch_addr,
    input  logic                         enable,
    input  logic                         hit,
    input  logic                         inv_all,
    input  logic                         line_inv,
    input  logic [IDX_W-1:0]             line_inv_idx,
    input  logic                         bus_ack,
    input  logic [DATA_W-1:0]            bus_rdata,
    output logic                         bus_req,
    output logic [ADDR_W-1:0]            bus_addr,
    output logic                         idle,
    output logic                         fill_active,
    output logic                         resp_valid,
    output logic [DATA_W-1:0]            resp_data,
    output logic                         wr_en,
    output logic [IDX_W-1:0]             wr_idx,
    output logic [TAG_W-1:0]             wr_tag,
    output logic                         wr_set,
    output logic [WORDS-1:0][DATA_W-1:0] wr_line
);

    typedef struct packed {
        ic_state_e                    st;
        logic [WSEL_W-1:0]            cnt;
        logic [TAG_W-1:0]             tag;
        logic [IDX_W-1:0]             idx;
        logic [WSEL_W-1:0]            word;
        logic                         killed;
        logic [WORDS-1:0][DATA_W-1:0] lfb;
    } fill_regs_t;

    localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(WORDS - 1);

    fill_regs_t r_d, r_q;
    logic       kill;

    always_comb begin
        r_d        = r_q;
        bus_req    = 1'b0;
        bus_addr   = {r_q.tag, r_q.idx, r_q.cnt, 2'b00};
        resp_valid = 1'b0;
        wr_en      = 1'b0;
        kill       = inv_all | (line_inv && (line_inv_idx == r_q.idx));

        unique case (r_q.st)
            ST_IDLE: begin
                if (fetch_req && !hit) begin
                    r_d.tag    = fetch_addr[ADDR_W-1:OFF_W+IDX_W];
                    r_d.idx    = fetch_addr[OFF_W+IDX_W-1:OFF_W];
                    r_d.word   = fetch_addr[OFF_W-1:2];
                    r_d.cnt    = '0;
                    r_d.killed = 1'b0;
                    r_d.st     = enable ? ST_FILL : ST_SINGLE;
                end
            end
            ST_FILL: begin
                bus_req    = 1'b1;
                r_d.killed = r_q.killed | kill;
                if (bus_ack) begin
                    r_d.lfb[r_q.cnt] = bus_rdata;
                    r_d.cnt          = r_q.cnt + 1'b1;
                    if (r_q.cnt == LAST_WORD) begin
                        wr_en  = 1'b1;
                        r_d.st = ST_RESP;
                    end
                end
            end
            ST_SINGLE: begin
                bus_req  = 1'b1;
                bus_addr = {r_q.tag, r_q.idx, r_q.word, 2'b00};
                if (bus_ack) begin
                    r_d.lfb[r_q.word] = bus_rdata;
                    r_d.st            = ST_RESP;
                end
            end
            ST_RESP: begin
                resp_valid = 1'b1;
                r_d.st     = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign idle        = (r_q.st == ST_IDLE);
    assign fill_active = (r_q.st == ST_FILL);
    assign resp_data   = r_q.lfb[r_q.word];
    assign wr_idx      = r_q.idx;
    assign wr_tag      = r_q.tag;
    // a kill in the completing cycle itself is applied by the tag store
    assign wr_set      = !r_q.killed;
    assign wr_line     = r_d.lfb;

endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
    import icache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINES      = 64,
    parameter int LINE_BYTES = 16,
    parameter int DATA_W     = 32,
    localparam int WORDS  = LINE_BYTES / (DATA_W / 8),
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int OFF_W  = WSEL_W + 2,
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:2] fetch_addr,
    output logic              fetch_ready,
    output logic [DATA_W-1:0] fetch_data,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              ctrl_wr,
    input  logic [1:0]        ctrl_wdata,
    output logic [1:0]        ctrl_rdata,
    input  logic              line_inv,
    input  logic [IDX_W-1:0]  line_inv_idx
);

    typedef struct packed {
        logic en;
    } ctrl_regs_t;

    ctrl_regs_t ctrl_d, ctrl_q;

    logic                         inv_all;
    logic [IDX_W-1:0]             f_idx;
    logic [TAG_W-1:0]             f_tag;
    logic [WSEL_W-1:0]            f_word;
    logic [TAG_W-1:0]             st_tag;
    logic                         st_valid;
    logic [DATA_W-1:0]            st_data;
    logic                         lookup_hit;
    logic                         idle;
    logic                         fill_active;
    logic                         resp_valid;
    logic [DATA_W-1:0]            resp_data;
    logic                         wr_en;
    logic [IDX_W-1:0]             wr_idx;
    logic [TAG_W-1:0]             wr_tag;
    logic                         wr_set;
    logic [WORDS-1:0][DATA_W-1:0] wr_line;

    always_comb begin
        ctrl_d  = ctrl_q;
        inv_all = ctrl_wr && ctrl_wdata[CTL_INVALL_BIT];
        if (ctrl_wr) begin
            ctrl_d.en = ctrl_wdata[CTL_EN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_rdata = {1'b0, ctrl_q.en};

    assign f_idx  = fetch_addr[OFF_W+IDX_W-1:OFF_W];
    assign f_tag  = fetch_addr[ADDR_W-1:OFF_W+IDX_W];
    assign f_word = fetch_addr[OFF_W-1:2];

    assign lookup_hit = fetch_req && ctrl_q.en && idle && st_valid && (st_tag == f_tag);

    icache_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (f_idx),
        .rd_tag   (st_tag),
        .rd_valid (st_valid),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_tag),
        .wr_set   (wr_set),
        .inv_all  (inv_all),
        .inv_line (line_inv),
        .inv_idx  (line_inv_idx)
    );

    icache_data_store #(
        .LINES  (LINES),
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_line (wr_line),
        .rd_idx  (f_idx),
        .rd_word (f_word),
        .rd_data (st_data)
    );

    icache_fill_ctrl #(
        .ADDR_W (ADDR_W),
        .LINES  (LINES),
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_fill (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_req    (fetch_req),
        .fetch_addr   (fetch_addr),
        .enable       (ctrl_q.en),
        .hit          (lookup_hit),
        .inv_all      (inv_all),
        .line_inv     (line_inv),
        .line_inv_idx (line_inv_idx),
        .bus_ack      (bus_ack),
        .bus_rdata    (bus_rdata),
        .bus_req      (bus_req),
        .bus_addr     (bus_addr),
        .idle         (idle),
        .fill_active  (fill_active),
        .resp_valid   (resp_valid),
        .resp_data    (resp_data),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_tag       (wr_tag),
        .wr_set       (wr_set),
        .wr_line      (wr_line)
    );

    assign fetch_ready = lookup_hit || resp_valid;
    assign fetch_data  = resp_valid ? resp_data : st_data;

endmodule

// File: rtl/icache_checker.sv
module icache_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_ready,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              ctrl_wr,
    input logic [1:0]        ctrl_wdata,
    input logic [1:0]        ctrl_rdata,
    input logic              fill_active,
    input logic              lookup_hit
);

    AST_BUS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr[1:0] == 2'b00));  // R9

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));  // R9

    AST_FILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_active && bus_ack && (bus_addr[3:2] != 2'b11))
            |=> (bus_req && (bus_addr == $past(bus_addr) + 4)));  // R4

    AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_hit |-> (fetch_ready && !bus_req));  // R3

    AST_UNCACHED_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ready && !ctrl_rdata[0]) |-> $past(bus_ack));  // R5

    AST_FLUSH_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[1]) |=> !lookup_hit);  // R6

endmodule

bind ifetch_cache icache_checker #(.ADDR_W(ADDR_W)) u_icache_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_ready (fetch_ready),
    .bus_req     (bus_req),
    .bus_addr    (bus_addr),
    .bus_ack     (bus_ack),
    .ctrl_wr     (ctrl_wr),
    .ctrl_wdata  (ctrl_wdata),
    .ctrl_rdata  (ctrl_rdata),
    .fill_active (fill_active),
    .lookup_hit  (lookup_hit)
);

// File: tb/ifetch_cache_bench.sv
`timescale 1ns/1ps
module ifetch_cache_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:2] fetch_addr = '0;
    logic        fetch_ready;
    logic [31:0] fetch_data;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        ctrl_wr = 1'b0;
    logic [1:0]  ctrl_wdata = '0;
    logic [1:0]  ctrl_rdata;
    logic        line_inv = 1'b0;
    logic [5:0]  line_inv_idx = '0;

    int checks = 0;
    int fails  = 0;

    // reference model state
    bit          ref_en = 1'b0;
    bit          ref_valid [64];
    logic [21:0] ref_tag [64];
    logic [31:0] bus_log [$];
    int          lat = 0;
    int          wcnt = 0;

    always #2.5 clk = ~clk;

    ifetch_cache u_ifetch_cache (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_req    (fetch_req),
        .fetch_addr   (fetch_addr),
        .fetch_ready  (fetch_ready),
        .fetch_data   (fetch_data),
        .bus_req      (bus_req),
        .bus_addr     (bus_addr),
        .bus_ack      (bus_ack),
        .bus_rdata    (bus_rdata),
        .ctrl_wr      (ctrl_wr),
        .ctrl_wdata   (ctrl_wdata),
        .ctrl_rdata   (ctrl_rdata),
        .line_inv     (line_inv),
        .line_inv_idx (line_inv_idx)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ 32'h0BAD_F00D;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // memory bus responder with latency of 0..2 idle cycles
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req && rst_n) begin
                if (wcnt >= lat) begin
                    bus_ack   = 1'b1;
                    bus_rdata = memf(bus_addr);
                    bus_log.push_back(bus_addr);
                    wcnt = 0;
                    lat  = (lat + 1) % 3;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // per-clock comparison of the control readback against the model (R6)
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n) begin
                chk(ctrl_rdata == {1'b0, ref_en}, "R6", "ctrl readback",
                    32'(ctrl_rdata), 32'({1'b0, ref_en}));
            end
        end
    end

    task automatic ctrl_write(input logic [1:0] v);
        @(negedge clk);
        ctrl_wr    = 1'b1;
        ctrl_wdata = v;
        @(posedge clk);
        #1;
        ref_en = v[0];
        if (v[1]) begin
            for (int i = 0; i < 64; i++) ref_valid[i] = 1'b0;
        end
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic inv_one(input logic [5:0] idx);
        @(negedge clk);
        line_inv     = 1'b1;
        line_inv_idx = idx;
        @(negedge clk);
        line_inv = 1'b0;
        ref_valid[idx] = 1'b0;
    endtask

    // mode: 0 plain, 1 invalidate own line mid-fill, 2 invalidate all mid-fill
    task automatic fetch(input logic [31:0] a, input int mode, input string req);
        logic [5:0]  idx;
        logic [21:0] tg;
        bit          exp_hit;
        bit          was_en;
        int          waits;
        logic [31:0] got;
        logic [31:0] base;
        idx     = a[9:4];
        tg      = a[31:10];
        base    = {a[31:4], 4'b0000};
        was_en  = ref_en;
        exp_hit = ref_en && ref_valid[idx] && (ref_tag[idx] == tg);
        @(negedge clk);
        bus_log.delete();
        fetch_addr = a[31:2];
        fetch_req  = 1'b1;
        waits      = 0;
        forever begin
            #1;
            if (fetch_ready) break;
            @(negedge clk);
            line_inv = 1'b0;
            ctrl_wr  = 1'b0;
            waits++;
            if (waits == 2 && mode == 1) begin
                line_inv     = 1'b1;
                line_inv_idx = idx;
            end
            if (waits == 2 && mode == 2) begin
                ctrl_wr    = 1'b1;
                ctrl_wdata = {1'b1, ref_en};
            end
        end
        got = fetch_data;
        @(negedge clk);
        fetch_req = 1'b0;
        line_inv  = 1'b0;
        ctrl_wr   = 1'b0;

        chk(got == memf(a), req, "fetch word", got, memf(a));
        if (exp_hit) begin
            chk(waits == 0, "R3", "hit latency", 32'(waits), 32'd0);
            chk(bus_log.size() == 0, "R3", "hit bus reads", 32'(bus_log.size()), 32'd0);
        end else if (was_en) begin
            chk(bus_log.size() == 4, "R4", "fill bus reads", 32'(bus_log.size()), 32'd4);
            for (int k = 0; k < 4 && k < bus_log.size(); k++) begin
                chk(bus_log[k] == base + 32'(4 * k), "R4", "fill order",
                    bus_log[k], base + 32'(4 * k));
            end
            if (mode == 2) begin
                for (int i = 0; i < 64; i++) ref_valid[i] = 1'b0;
            end else begin
                ref_valid[idx] = (mode == 0);
                ref_tag[idx]   = tg;
            end
        end else begin
            chk(bus_log.size() == 1, "R5", "uncached bus reads", 32'(bus_log.size()), 32'd1);
            if (bus_log.size() == 1) begin
                chk(bus_log[0] == {a[31:2], 2'b00}, "R5", "uncached address",
                    bus_log[0], {a[31:2], 2'b00});
            end
        end
    endtask

    // hit/miss classification check against the model without side effects
    task automatic expect_kind(input logic [31:0] a, input bit want_hit, input string req);
        bit model_hit;
        model_hit = ref_en && ref_valid[a[9:4]] && (ref_tag[a[9:4]] == a[31:10]);
        chk(model_hit == want_hit, req, "model hit expectation",
            32'(model_hit), 32'(want_hit));
        fetch(a, 0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            ref_valid[i] = 1'b0;
            ref_tag[i]   = '0;
        end
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(ctrl_rdata == 2'b00, "R1", "ctrl after reset", 32'(ctrl_rdata), 32'd0);
        chk(!fetch_ready && !bus_req, "R1", "idle after reset",
            32'({fetch_ready, bus_req}), 32'd0);

        // R5: uncached fetch, no install
        fetch(32'h0000_0108, 0, "R5");
        ctrl_write(2'b01);
        expect_kind(32'h0000_0108, 1'b0, "R1");      // miss: invalid after reset
        expect_kind(32'h0000_0100, 1'b1, "R3");
        expect_kind(32'h0000_010C, 1'b1, "R3");

        // R2: same index, different tag
        expect_kind(32'h0000_0504, 1'b0, "R2");
        expect_kind(32'h0000_0500, 1'b1, "R2");
        expect_kind(32'h0000_0104, 1'b0, "R2");
        expect_kind(32'hFFFF_FC3C, 1'b0, "R2");
        expect_kind(32'hFFFF_FC30, 1'b1, "R2");

        // R7: single line invalidate spares neighbours
        fetch(32'h0000_0200, 0, "R4");
        inv_one(6'h20);
        expect_kind(32'h0000_0104, 1'b1, "R7");
        expect_kind(32'h0000_0208, 1'b0, "R7");

        // R6: invalidate all, bit reads back zero (per-clock monitor)
        ctrl_write(2'b11);
        expect_kind(32'h0000_0100, 1'b0, "R6");
        expect_kind(32'h0000_0208, 1'b0, "R6");

        // R5: disabled fetch keeps stored lines
        ctrl_write(2'b00);
        fetch(32'h0000_0104, 0, "R5");
        fetch(32'h0000_0700, 0, "R5");
        ctrl_write(2'b01);
        expect_kind(32'h0000_0108, 1'b1, "R5");
        expect_kind(32'h0000_0700, 1'b0, "R5");

        // R8: invalidate during fill
        fetch(32'h0000_0304, 1, "R8");
        expect_kind(32'h0000_0300, 1'b0, "R8");
        fetch(32'h0000_0408, 2, "R8");
        expect_kind(32'h0000_0108, 1'b0, "R8");
        expect_kind(32'h0000_0400, 1'b0, "R8");
        expect_kind(32'h0000_0404, 1'b1, "R8");

        // R4: a sweep of lines then rereads
        for (int n = 0; n < 8; n++) fetch(32'h0001_0000 + 32'(n * 16 + 4), 0, "R4");
        for (int n = 0; n < 8; n++) expect_kind(32'h0001_0000 + 32'(n * 16 + 8), 1'b1, "R3");

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule